// File: doc/BRIEF.md
# Date Sequence Seven-Segment Driver

This block drives one common-cathode seven-segment display so that it steps through a fixed date of eight characters in MM-DD-YY form. A dash separates each pair of fields. A 3-bit step counter picks the character. The counter advances only when two enables are both high, and it wraps from 7 back to 0. It has a synchronous active-low clear and a synchronous active-low parallel load. A carry output lets a wider counter be built around it.

The six date digits are build-time parameters. Each step is decoded into the segment lines a to g, and the result is registered, so decode glitches never reach the display pins. The enables are normally held high and toggled by a slow tick, so each character stays on the display long enough to be read. The current step is also presented as an output.

Top module: `dob_date_display`

## Requirements
- R1: When `clr_n` and `load_n` are high and both `en_par` and `en_trk` are high, `step` increments by one at the clock edge, and it goes from 7 to 0.
- R2: When `clr_n` and `load_n` are high and either enable is low, `step` keeps its value across the clock edge.
- R3: When `clr_n` is low at a clock edge, `step` becomes 0 and `seg` becomes 7'h00 (all segments dark). This wins over load and over counting.
- R4: When `clr_n` is high and `load_n` is low at a clock edge, `step` takes the value of `load_val`, whatever the enables are.
- R5: `carry` is high exactly when `step` equals 7 and `en_trk` is high. `en_par` has no effect on it.
- R6: `seg` is registered. After any edge where `clr_n` is high, `seg` shows the glyph for the value `step` held before that edge. Bit 0 of `seg` is segment a, and bits 1 to 6 are segments b to g in that order.
- R7: The steps map to characters in this order: 0 month tens, 1 month ones, 2 dash, 3 day tens, 4 day ones, 5 dash, 6 year tens, 7 year ones. With the default parameters the display reads 1,0,-,2,7,-,8,4.
- R8: A segment is lit when its bit is 1. The dash lights only g (7'h40). The digit glyphs are 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F (hex, in the bit order of R6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr_n | input | 1 | Synchronous clear, active low; highest priority |
| load_n | input | 1 | Synchronous load, active low |
| load_val | input | 3 | Value taken into the step counter on load |
| en_par | input | 1 | Count enable, first of two |
| en_trk | input | 1 | Count enable, second of two; also gates `carry` |
| seg | output | 7 | Registered segment lines, bit 0 = a through bit 6 = g |
| step | output | 3 | Current step index |
| carry | output | 1 | Terminal-count carry for cascading |

## Verification
Clear, load and counting can all be requested in the same cycle, and the priority between them decides the next step. The bench drives directed cycles with clear and load low together, and load low with both enables high. It also mixes random combinations of all three controls. A bench model that applies clear, then load, then count predicts the next step and the registered glyph, and the design's outputs are compared against that model after every edge.

// File: rtl/dob_pkg.sv
package dob_pkg;

    localparam int STEP_W  = 3;
    localparam int NSTEPS  = 1 << STEP_W;
    localparam int SEG_W   = 7;
    localparam int NDIGITS = 6;

    typedef logic [STEP_W-1:0] step_t;
    typedef logic [SEG_W-1:0]  seg_t;
    typedef logic [NDIGITS-1:0][3:0] digits_t;

    typedef enum logic {CH_DIGIT = 1'b0, CH_DASH = 1'b1} char_kind_t;

    typedef struct packed {
        char_kind_t kind;
        logic [3:0] value;
    } char_t;

    typedef struct packed {
        logic clear;
        logic load;
        logic advance;
    } cnt_ctrl_t;

    localparam seg_t SEG_OFF  = 7'h00;
    localparam seg_t SEG_DASH = 7'h40;

    // Segment pattern for one decimal digit; bit 0 = a ... bit 6 = g.
    function automatic seg_t digit_glyph(input logic [3:0] d);
        seg_t s;
        case (d)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = SEG_OFF;
        endcase
        return s;
    endfunction

    // Character shown at a given step: separators sit at steps 2 and 5.
    function automatic char_t char_at(input int pos, input digits_t dg);
        char_t c;
        int    idx;
        c.kind  = CH_DIGIT;
        c.value = 4'd0;
        if (pos == 2 || pos == 5) begin
            c.kind = CH_DASH;
        end else begin
            idx     = (pos < 2) ? pos : ((pos < 5) ? pos - 1 : pos - 2);
            c.value = dg[idx];
        end
        return c;
    endfunction

    function automatic seg_t render(input char_t c);
        return (c.kind == CH_DASH) ? SEG_DASH : digit_glyph(c.value);
    endfunction

endpackage

// File: rtl/dob_step_counter.sv
module dob_step_counter
    import dob_pkg::*;
(
    input  logic      clk,
    input  cnt_ctrl_t ctrl,
    input  step_t     load_val,
    output step_t     step
);
    step_t step_q;

    always_ff @(posedge clk) begin
        if (ctrl.clear) begin
            step_q <= '0;
        end else if (ctrl.load) begin
            step_q <= load_val;
        end else if (ctrl.advance) begin
            step_q <= step_q + step_t'(1);
        end
    end

    assign step = step_q;
endmodule

// File: rtl/dob_glyph_decode.sv
module dob_glyph_decode
    import dob_pkg::*;
#(
    parameter digits_t DIGITS = '0
) (
    input  step_t step,
    output seg_t  seg
);
    seg_t pattern [NSTEPS];

    for (genvar i = 0; i < NSTEPS; i++) begin : g_step
        localparam seg_t GLYPH = render(char_at(i, DIGITS));
        assign pattern[i] = GLYPH;
    end

    assign seg = pattern[step];
endmodule

// File: rtl/dob_seg_reg.sv
module dob_seg_reg
    import dob_pkg::*;
(
    input  logic clk,
    input  logic clear,
    input  seg_t seg_d,
    output seg_t seg_q
);
    seg_t q;

    always_ff @(posedge clk) begin
        if (clear) begin
            q <= SEG_OFF;
        end else begin
            q <= seg_d;
        end
    end

    assign seg_q = q;
endmodule

// File: rtl/dob_date_display.sv
module dob_date_display
    import dob_pkg::*;
#(
    parameter int MON_TENS = 1,
    parameter int MON_ONES = 0,
    parameter int DAY_TENS = 2,
    parameter int DAY_ONES = 7,
    parameter int YR_TENS  = 8,
    parameter int YR_ONES  = 4
) (
    input  logic       clk,
    input  logic       clr_n,
    input  logic       load_n,
    input  logic [2:0] load_val,
    input  logic       en_par,
    input  logic       en_trk,
    output logic [6:0] seg,
    output logic [2:0] step,
    output logic       carry
);
    localparam digits_t DATE_DIGITS = {
        4'(YR_ONES), 4'(YR_TENS), 4'(DAY_ONES),
        4'(DAY_TENS), 4'(MON_ONES), 4'(MON_TENS)
    };

    cnt_ctrl_t ctrl;
    step_t     step_w;
    seg_t      seg_next;
    seg_t      seg_w;

    always_comb begin
        ctrl.clear   = ~clr_n;
        ctrl.load    = ~load_n;
        ctrl.advance = en_par & en_trk;
    end

    dob_step_counter u_cnt (
        .clk      (clk),
        .ctrl     (ctrl),
        .load_val (load_val),
        .step     (step_w)
    );

    dob_glyph_decode #(.DIGITS(DATE_DIGITS)) u_dec (
        .step (step_w),
        .seg  (seg_next)
    );

    dob_seg_reg u_sreg (
        .clk   (clk),
        .clear (ctrl.clear),
        .seg_d (seg_next),
        .seg_q (seg_w)
    );

    assign step  = step_w;
    assign seg   = seg_w;
    assign carry = en_trk & (step_w == step_t'(NSTEPS - 1));
endmodule

// File: rtl/dob_date_display_chk.sv
module dob_date_display_chk (
    input logic       clk,
    input logic       clr_n,
    input logic       load_n,
    input logic [2:0] load_val,
    input logic       en_par,
    input logic       en_trk,
    input logic [6:0] seg,
    input logic [2:0] step,
    input logic       carry
);
    logic started = 1'b0;
    always_ff @(posedge clk) begin
        if (!clr_n) started <= 1'b1;
    end

    // R1
    a_r1_wrap: assert property (@(posedge clk) disable iff (!clr_n)
        (started && load_n && en_par && en_trk && step == 3'd7) |=> (step == 3'd0));

    // R2
    a_r2_hold: assert property (@(posedge clk) disable iff (!clr_n)
        (started && load_n && !(en_par && en_trk)) |=> $stable(step));

    // R3
    a_r3_clear: assert property (@(posedge clk) disable iff (!clr_n)
        (started && $rose(clr_n)) |-> (step == 3'd0 && seg == 7'h00));

    // R4
    a_r4_load: assert property (@(posedge clk) disable iff (!clr_n)
        (started && !load_n) |=> (step == $past(load_val)));

    // R5
    a_r5_carry: assert property (@(posedge clk) disable iff (!clr_n)
        started |-> (carry == (en_trk && step == 3'd7)));

    // R6 / R8: separator steps lead to a lone g segment one edge later
    a_r6_dash_lag: assert property (@(posedge clk) disable iff (!clr_n)
        (started && (step == 3'd2 || step == 3'd5)) |=> (seg == 7'h40));
endmodule

bind dob_date_display dob_date_display_chk u_chk (
    .clk      (clk),
    .clr_n    (clr_n),
    .load_n   (load_n),
    .load_val (load_val),
    .en_par   (en_par),
    .en_trk   (en_trk),
    .seg      (seg),
    .step     (step),
    .carry    (carry)
);

// File: tb/sim_dob_date_display.sv
`timescale 1ns/1ps
module sim_dob_date_display;

    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic       load_n = 1'b1;
    logic [2:0] load_val = 3'd0;
    logic       en_par = 1'b0;
    logic       en_trk = 1'b0;
    logic [6:0] seg;
    logic [2:0] step;
    logic       carry;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dob_date_display u0 (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .load_val(load_val),
        .en_par(en_par), .en_trk(en_trk), .seg(seg), .step(step), .carry(carry)
    );

    // Model state
    logic [2:0] m_step;
    logic [6:0] m_seg;
    bit         m_known = 0;

    // R8 glyph table
    function automatic logic [6:0] glyph(input int d);
        case (d)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
            4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
            8: return 7'h7F; 9: return 7'h6F; default: return 7'h00;
        endcase
    endfunction

    // R7 character order for the default date 10-27-84; -1 marks a dash
    function automatic logic [6:0] exp_seg(input logic [2:0] s);
        int seq [8] = '{1, 0, -1, 2, 7, -1, 8, 4};
        if (seq[s] < 0) return 7'h40;
        return glyph(seq[s]);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: check registered outputs, drive, check carry, clock, update model
    task automatic cyc(input bit c, input bit l, input logic [2:0] v,
                       input bit p, input bit t, input string tag);
        @(negedge clk);
        if (m_known) begin
            chk({tag, " step (R1/R2/R3/R4)"}, step, m_step);
            chk({tag, " seg (R6/R7/R8)"}, seg, m_seg);
        end
        clr_n = c; load_n = l; load_val = v; en_par = p; en_trk = t;
        #0.5;
        if (m_known) chk({tag, " carry R5"}, carry, (t && m_step == 3'd7));
        @(posedge clk);
        if (!c) begin
            m_seg  = 7'h00;
            m_step = 3'd0;
            m_known = 1;
        end else if (m_known) begin
            m_seg = exp_seg(m_step);
            if (!l)          m_step = v;
            else if (p && t) m_step = m_step + 3'd1;
        end
    endtask

    task automatic run_all();
        int unused_seed;
        unused_seed = $urandom(32'd1729);
        // R3 reset state
        cyc(0, 1, 3'd0, 0, 0, "reset");
        cyc(1, 1, 3'd0, 0, 0, "post-clear R3");
        // R1/R7: two full passes through the date
        for (int i = 0; i < 17; i++) cyc(1, 1, 3'd0, 1, 1, "count R1 R7");
        // R2: each enable low alone
        cyc(1, 1, 3'd0, 0, 1, "hold en_par R2");
        cyc(1, 1, 3'd0, 1, 0, "hold en_trk R2");
        cyc(1, 1, 3'd0, 0, 0, "hold R2");
        // R4: load over counting, load 7 then carry R5 with en_par low
        cyc(1, 0, 3'd7, 1, 1, "load R4");
        cyc(1, 1, 3'd0, 0, 1, "carry R5");
        cyc(1, 1, 3'd0, 0, 0, "carry off R5");
        cyc(1, 1, 3'd0, 1, 1, "wrap R1");
        cyc(1, 1, 3'd0, 1, 1, "after wrap R1");
        // R3: clear beats load and count in the same cycle
        cyc(1, 0, 3'd5, 0, 0, "load dash R4");
        cyc(0, 0, 3'd6, 1, 1, "clear wins R3");
        cyc(1, 1, 3'd0, 0, 0, "blank R3");
        cyc(1, 0, 3'd2, 1, 1, "load R4");
        cyc(1, 1, 3'd0, 0, 0, "dash R8");
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom % 100);
            cyc((r >= 3), (($urandom % 8) != 0), 3'($urandom), (($urandom % 4) != 0),
                (($urandom % 4) != 0), "random");
        end
        cyc(1, 1, 3'd0, 0, 0, "final");
    endtask

    initial begin
        bit timed_out = 0;
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule